// File: doc/BRIEF.md
# Multi-channel wait/hold PWM controller

This block generates seven independent pulse-width-modulated waveforms from one counting clock. Each channel holds its output high for a programmed number of cycles (the wait count) and then low for a second programmed number of cycles (the hold count), and repeats. The period is the sum of the two counts, so software sets the duty cycle and the frequency through two plain cycle counts rather than a period and a compare value. Channels 0 to 5 leave the block on external pins. Channel 6 is kept for on-chip use.

Every channel has a bypass switch that routes the source reference straight to its output. It also has an output enable, and two clock gates in series: a pre-divider gate and a post-divider gate. Its counter advances only while both gates are open. Clearing the pre-divider gate parks the counter at the start of the high phase. Clearing only the post-divider gate freezes the waveform where it stands. A 3-bit source-select field and a transition-mode bit per channel are stored and read back. Only one source and only the normal mode exist, so these fields have no effect on the output.

The counters run on `clk`, which is the source clock. `src_lvl` is the source reference level for bypass, supplied in the same clock domain. All configuration goes through a synchronous word-wide write port with a combinational read port.

Top module: `wh_pwm_ctrl`

## Requirements
- R1: After synchronous active-low reset, every register reads 0 and every channel output is low.
- R2: Registers read back only their implemented bits. Offset 0x00 holds 21 select bits [20:0] and 7 bypass bits [27:21]. Offset 0x04 holds output enables [6:0] and mode bits [13:7]. Offsets 0x08 and 0x0C hold pre and post gates [6:0]. Each 16-bit wait count is at 0x10+8n and each 16-bit hold count at 0x14+8n. Every unmapped offset reads 0.
- R3: When running in divider mode, channel n is high for exactly wait cycles and low for exactly hold cycles, repeating.
- R4: A wait or hold value of 0 acts as 1, giving a minimum period of 2 cycles.
- R5: The counts are 16 bits wide, and a long setting (hundreds of cycles) gives exactly that many cycles per phase.
- R6: With bypass bit 21+n set, output n equals `src_lvl` in the same cycle, whatever the wait and hold values are.
- R7: With output-enable bit n clear, output n is low. Channel 6 appears only on `pwm_int_o`.
- R8: With pre gate bit n clear, the channel sits at the start of its high phase, and its output is high if enabled. With the pre gate set and post gate bit n clear, the output holds its level.
- R9: Wait and hold values written mid-period take effect only at the next period boundary. The period in progress completes with the old values.
- R10: Channels are independent: different settings on two channels give each its own waveform at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source/counting clock and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 1 | Source reference level routed out in bypass |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_pin_o | output | 6 | External channel outputs 0 to 5 |
| pwm_int_o | output | 1 | Internal channel 6 output |

## Verification
The hardest state to reach is a count update that lands inside a running period. The write has to arrive after the high phase has begun and before the hold phase ends. A pending value that was loaded too early looks correct unless both the current period and the next one are measured. The bench therefore synchronises to a rising output edge and writes new counts a few cycles into the high phase. It then measures the remainder of that period against the old values and the following period against the new ones. The freeze and park conditions of the two gates are reached by toggling one gate at a time on a running channel and watching the output level for many cycles.

// File: rtl/wh_pwm_pkg.sv
// Package: register offsets and layout constants for the wait/hold PWM block.
// Assumes byte offsets on a word-aligned register port.
package wh_pwm_pkg;
    localparam int unsigned OFS_CLKSEL = 8'h00;  // select fields + bypass bits
    localparam int unsigned OFS_OE     = 8'h04;  // output enables + mode bits
    localparam int unsigned OFS_PRE    = 8'h08;  // pre-divider gates
    localparam int unsigned OFS_POST   = 8'h0C;  // post-divider gates
    localparam int unsigned OFS_CH     = 8'h10;  // first channel count pair
    localparam int unsigned CH_STRIDE  = 8;      // bytes per channel pair
    localparam int unsigned SEL_W      = 3;      // source-select field width
endpackage

// File: rtl/wh_pwm_regs.sv
// Register file: stores all control fields and per-channel counts, decodes
// writes, and returns implemented bits on reads (zero for unmapped offsets).
// Assumes one write per cycle; read data is combinational from reg_addr.
module wh_pwm_regs
    import wh_pwm_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    output logic [NUM_CH-1:0]             bypass,
    output logic [NUM_CH-1:0]             oe,
    output logic [NUM_CH-1:0]             pre_en,
    output logic [NUM_CH-1:0]             post_en,
    output logic [NUM_CH-1:0][CNT_W-1:0]  wait_cnt,
    output logic [NUM_CH-1:0][CNT_W-1:0]  hold_cnt
);
    localparam int SELB = SEL_W * NUM_CH;
    localparam int CSW  = SELB + NUM_CH;

    logic [SELB-1:0]   sel_q;
    logic [NUM_CH-1:0] mode_q;

    // Register update on writes; synchronous reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            bypass   <= '0;
            oe       <= '0;
            mode_q   <= '0;
            pre_en   <= '0;
            post_en  <= '0;
            wait_cnt <= '0;
            hold_cnt <= '0;
        end else if (we) begin
            if (32'(addr) == OFS_CLKSEL) begin
                sel_q  <= wdata[SELB-1:0];
                bypass <= wdata[CSW-1:SELB];
            end
            if (32'(addr) == OFS_OE) begin
                oe     <= wdata[NUM_CH-1:0];
                mode_q <= wdata[2*NUM_CH-1:NUM_CH];
            end
            if (32'(addr) == OFS_PRE)  pre_en  <= wdata[NUM_CH-1:0];
            if (32'(addr) == OFS_POST) post_en <= wdata[NUM_CH-1:0];
            for (int c = 0; c < NUM_CH; c++) begin
                if (32'(addr) == OFS_CH + CH_STRIDE*c)     wait_cnt[c] <= wdata[CNT_W-1:0];
                if (32'(addr) == OFS_CH + CH_STRIDE*c + 4) hold_cnt[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read mux: implemented bits only, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (32'(addr) == OFS_CLKSEL) rdata[CSW-1:0]      = {bypass, sel_q};
        if (32'(addr) == OFS_OE)     rdata[2*NUM_CH-1:0] = {mode_q, oe};
        if (32'(addr) == OFS_PRE)    rdata[NUM_CH-1:0]   = pre_en;
        if (32'(addr) == OFS_POST)   rdata[NUM_CH-1:0]   = post_en;
        for (int c = 0; c < NUM_CH; c++) begin
            if (32'(addr) == OFS_CH + CH_STRIDE*c)     rdata[CNT_W-1:0] = wait_cnt[c];
            if (32'(addr) == OFS_CH + CH_STRIDE*c + 4) rdata[CNT_W-1:0] = hold_cnt[c];
        end
    end
endmodule

// File: rtl/wh_pwm_chan.sv
// One wait/hold channel: a phase flag and a cycle counter. Counts only while
// both gates are open; the pre gate closed parks it at the high-phase start
// and reloads the pending counts; new counts are latched at period end.
// Assumes counts of 0 mean 1 (minimum phase length of one cycle).
module wh_pwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_en,
    input  logic             post_en,
    input  logic [CNT_W-1:0] wait_cfg,
    input  logic [CNT_W-1:0] hold_cfg,
    output logic             phase_hi
);
    logic [CNT_W-1:0] cnt, sh_wait, sh_hold, cur_len, wait_eff, hold_eff;
    logic             last;

    // Zero-to-one clamp and length of the phase in progress.
    always_comb begin
        wait_eff = (wait_cfg == '0) ? CNT_W'(1) : wait_cfg;
        hold_eff = (hold_cfg == '0) ? CNT_W'(1) : hold_cfg;
        cur_len  = phase_hi ? sh_wait : sh_hold;
        last     = (cnt == cur_len - CNT_W'(1));
    end

    // Phase/counter sequencing with gate handling and boundary reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            phase_hi <= 1'b1;
            sh_wait  <= CNT_W'(1);
            sh_hold  <= CNT_W'(1);
        end else if (!pre_en) begin
            cnt      <= '0;
            phase_hi <= 1'b1;
            sh_wait  <= wait_eff;
            sh_hold  <= hold_eff;
        end else if (post_en) begin
            if (last) begin
                cnt      <= '0;
                phase_hi <= !phase_hi;
                if (!phase_hi) begin
                    sh_wait <= wait_eff;
                    sh_hold <= hold_eff;
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < cur_len); // R3
    AST_PARK_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_en |=> (cnt == '0) && phase_hi); // R8
    AST_FREEZE_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !post_en) |=> $stable(cnt) && $stable(phase_hi)); // R8
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && (phase_hi || !last)) |=> $stable(sh_wait) && $stable(sh_hold)); // R9
endmodule

// File: rtl/wh_pwm_ctrl.sv
// Top: register file plus one generated wait/hold channel per output.
// Output stage applies bypass (source level) and output enable per channel.
// Assumes clk is the counting source; src_lvl is in the clk domain.
module wh_pwm_ctrl
    import wh_pwm_pkg::*;
#(
    parameter int NUM_CH  = 7,
    parameter int NUM_EXT = 6,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_lvl,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_EXT-1:0] pwm_pin_o,
    output logic               pwm_int_o
);
    logic [NUM_CH-1:0]            bypass, oe, pre_en, post_en, ph, ch_out;
    logic [NUM_CH-1:0][CNT_W-1:0] wait_cnt, hold_cnt;

    wh_pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .bypass(bypass), .oe(oe),
        .pre_en(pre_en), .post_en(post_en), .wait_cnt(wait_cnt),
        .hold_cnt(hold_cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wh_pwm_chan #(.CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .pre_en(pre_en[g]),
            .post_en(post_en[g]), .wait_cfg(wait_cnt[g]),
            .hold_cfg(hold_cnt[g]), .phase_hi(ph[g])
        );
        // Output stage: enable gate, then bypass or divider waveform.
        assign ch_out[g] = oe[g] & (bypass[g] ? src_lvl : ph[g]);
    end

    assign pwm_pin_o = ch_out[NUM_EXT-1:0];
    assign pwm_int_o = ch_out[NUM_CH-1];
endmodule

// File: tb/wh_pwm_ctrl_tb_top.sv
// Directed bench for wh_pwm_ctrl: one task per scenario.
module wh_pwm_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_lvl = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  pwm_pin_o;
    logic        pwm_int_o;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    wh_pwm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_pin_o(pwm_pin_o), .pwm_int_o(pwm_int_o)
    );

    function automatic logic out_of(int ch);
        return (ch < 6) ? pwm_pin_o[ch] : pwm_int_o;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'(a);
        #1 d = reg_rdata;
    endtask

    // Measure one full period after the next rising edge of a channel.
    task automatic measure(int ch, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (out_of(ch) !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (out_of(ch) !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        while (out_of(ch) === 1'b1 && guard < 5000) begin hi++; @(negedge clk); guard++; end
        while (out_of(ch) === 1'b0 && guard < 5000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int offs[6] = '{0, 4, 8, 12, 16, 20};
        @(negedge clk);
        check("R1", "outputs after reset", {pwm_int_o, pwm_pin_o}, 0);
        foreach (offs[i]) begin
            rd(offs[i], d);
            check("R1", "register after reset", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2", "clksel mask", d, 32'h0FFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R2", "oe mask", d, 32'h3FFF);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2", "pre mask", d, 32'h7F);
        wr(8'h3C, 32'h0001_2345); rd(8'h3C, d); check("R2", "hold ch5 mask", d, 32'h2345);
        rd(8'h4C, d); check("R2", "unmapped 0x4C", d, 0);
        rd(8'h80, d); check("R2", "unmapped 0x80", d, 0);
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h08, 0); wr(8'h3C, 0);
    endtask

    task automatic t_divider(int ch, int w, int h, int ew, int eh, string req);
        int hi, lo;
        wr(8'h08, 0);
        wr(8'h10 + 8*ch, w); wr(8'h14 + 8*ch, h);
        wr(8'h04, 32'(1) << ch); wr(8'h0C, 32'h7F); wr(8'h08, 32'h7F);
        measure(ch, hi, lo);
        check(req, "high length", hi, ew);
        check(req, "low length", lo, eh);
    endtask

    task automatic t_bypass();
        int errs = 0;
        wr(8'h08, 0); wr(8'h18, 4); wr(8'h1C, 4);
        wr(8'h04, 32'h2); wr(8'h00, 32'(1) << 22); wr(8'h08, 32'h7F);
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1 src_lvl = (i % 3) == 0;
            @(negedge clk);
            if (pwm_pin_o[1] !== src_lvl) errs++;
        end
        check("R6", "bypass mismatches", errs, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_oe();
        int hi_seen = 0;
        wr(8'h30, 2); wr(8'h34, 2); wr(8'h04, 0); wr(8'h08, 32'h7F);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_pin_o[4]) hi_seen++;
        end
        check("R7", "disabled output high cycles", hi_seen, 0);
    endtask

    task automatic t_gates();
        int hi, lo, chg = 0;
        logic lvl;
        wr(8'h08, 0); wr(8'h20, 5); wr(8'h24, 5); wr(8'h04, 32'h4);
        wr(8'h0C, 32'h7F);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_pin_o[2] !== 1'b1) chg++;
        end
        check("R8", "parked output not high", chg, 0);
        wr(8'h08, 32'h7F);
        repeat (3) @(negedge clk);
        wr(8'h0C, 0);
        @(negedge clk); lvl = pwm_pin_o[2]; chg = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_pin_o[2] !== lvl) chg++;
        end
        check("R8", "frozen output changes", chg, 0);
        wr(8'h0C, 32'h7F);
        measure(2, hi, lo);
        check("R8", "period after unfreeze high", hi, 5);
        check("R8", "period after unfreeze low", lo, 5);
    endtask

    task automatic t_update();
        int hi = 0, lo = 0, hi2, lo2, guard = 0;
        wr(8'h08, 0); wr(8'h28, 10); wr(8'h2C, 10); wr(8'h04, 32'h8);
        wr(8'h0C, 32'h7F); wr(8'h08, 32'h7F);
        @(negedge clk);
        while (pwm_pin_o[3] !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (pwm_pin_o[3] !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        // rise seen at this negedge; counting: 1 high cycle observed
        hi = 1;
        @(negedge clk); hi++;
        reg_addr = 8'h28; reg_wdata = 4; reg_we = 1'b1;
        @(negedge clk); hi++;
        reg_addr = 8'h2C; reg_wdata = 2;
        @(negedge clk); reg_we = 1'b0;
        while (pwm_pin_o[3] === 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
        while (pwm_pin_o[3] === 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
        check("R9", "current high keeps old wait", hi, 10);
        check("R9", "current low keeps old hold", lo, 10);
        hi2 = 0; lo2 = 0;
        while (pwm_pin_o[3] === 1'b1 && guard < 300) begin hi2++; @(negedge clk); guard++; end
        while (pwm_pin_o[3] === 1'b0 && guard < 300) begin lo2++; @(negedge clk); guard++; end
        check("R9", "next high uses new wait", hi2, 4);
        check("R9", "next low uses new hold", lo2, 2);
    endtask

    task automatic t_indep();
        int h0, l0, h6, l6;
        wr(8'h08, 0);
        wr(8'h10, 3); wr(8'h14, 7); wr(8'h40, 6); wr(8'h44, 2);
        wr(8'h04, 32'h41); wr(8'h0C, 32'h7F); wr(8'h08, 32'h7F);
        fork
            measure(0, h0, l0);
            measure(6, h6, l6);
        join
        check("R10", "ch0 high", h0, 3);
        check("R10", "ch0 low", l0, 7);
        check("R10", "ch6 internal high", h6, 6);
        check("R10", "ch6 internal low", l6, 2);
        check("R7", "internal channel not on pins", pwm_pin_o[5:1], 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_divider(0, 3, 5, 3, 5, "R3");
        t_divider(5, 1, 1, 1, 1, "R3");
        t_divider(1, 0, 0, 1, 1, "R4");
        t_divider(2, 0, 4, 1, 4, "R4");
        t_divider(6, 300, 450, 300, 450, "R5");
        t_bypass();
        t_oe();
        t_gates();
        t_update();
        t_indep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule